// File: doc/BRIEF.md
# Two-Wire Debug Target Port

This block is the target end of a two-wire debug link. The serial clock from the debugger is the block's clock, and the single data line is split into an input, an output and an output enable. The debugger sends an 8-bit request. After one turnaround cycle the port drives a 3-bit acknowledge. The transfer then either carries 32 data bits plus a parity bit or ends at once.

Requests go either to a small set of local port registers or out to a simple valid/ready access bus. Access-bus reads are posted: each one returns the result of the previous access-bus read and starts a new one. That result is held in a read buffer, which the debugger can also fetch without touching the bus. The buffer therefore survives a lost link, and a read in flight can be recovered.

Error conditions are kept in sticky flags: data parity failure, access-bus error and overrun. While any flag is set, access-bus requests are refused with FAULT and have no effect. A write to the abort register clears the flags selected by its mask. All bits are launched and sampled on rising edges of the serial clock.

Top module: `swd_target_port`

## Requirements
- R1: A request is start=1, ap_sel, read, A[2], A[3], parity, stop=0, park=1, sent in that order. The parity bit is the XOR of ap_sel, read, A[2] and A[3]. A request with a bad start/stop/park/parity bit gets no driven response: the line stays released for the turnaround and the three acknowledge cycles. The next well-formed request is then served normally.
- R2: One turnaround cycle after the park bit, the port drives a 3-bit acknowledge, LSB first. OK=3'b001, WAIT=3'b010, FAULT=3'b100.
- R3: After an OK read acknowledge, the port drives 32 data bits LSB first, then one parity bit equal to the XOR of the data. It then releases the line for one turnaround cycle.
- R4: After an OK write acknowledge, there is one turnaround cycle, then the host drives 32 data bits LSB first and a parity bit. If the parity is wrong, the write is discarded and the data-error flag (control word bit 7) is set.
- R5: Local registers by A[3:2]: 0 reads the identity code; 1 is the control word; 2 reads zero; 3 reads the read buffer. In the control word, only bit 0 (overrun detect enable) is writable.
- R6: An OK access-bus write raises ap_valid with the address and data. These stay stable until ap_ready.
- R7: An OK access-bus read returns the read buffer in its data phase and starts a bus read. The buffer takes ap_rdata when that read completes.
- R8: An access-bus request while a bus access is still pending is answered WAIT, with no data phase and no new bus access.
- R9: A WAIT answer while control bit 0 is set sets the sticky overrun flag (control bit 1). With bit 0 clear, a WAIT leaves the flags unchanged.
- R10: A bus completion with ap_err set sets the sticky bus-error flag (control bit 4).
- R11: While any sticky flag is set, access-bus requests are answered FAULT, with no data phase and no bus access, and a refused write changes nothing. Local register requests are still answered OK.
- R12: A write to local address 0 clears each sticky flag whose bit is set in the written data (bits 1, 4, 7).
- R13: Reading local address 3 returns the buffered read data, starts no bus access, and returns the same value each time.
- R14: After reset the line is released, no bus access is pending and the control word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the debugger; all logic uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| swdio_in | input | 1 | Data line as seen at the pad |
| swdio_out | output | 1 | Value driven onto the data line |
| swdio_oe | output | 1 | High while the port drives the data line |
| ap_valid | output | 1 | Access-bus request pending |
| ap_write | output | 1 | Access-bus request is a write |
| ap_addr | output | 2 | Access-bus register address (A[3:2]) |
| ap_wdata | output | 32 | Access-bus write data |
| ap_ready | input | 1 | Access-bus completion |
| ap_rdata | input | 32 | Access-bus read data, valid with ap_ready |
| ap_err | input | 1 | Access-bus error, valid with ap_ready |

## Verification
The bench builds the port with a non-default identity code, so the identity read checks the parameter path and not a reset constant. It varies the latency of its bus responder between zero and 80 cycles. The long setting keeps an access pending across a whole following request, which brings WAIT, overrun latching and the posted-read buffer within reach. The zero setting lets sticky-flag refusal and abort clearing be observed back to back.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int REQ_BITS = 7;   // bits after the start bit
  localparam int ACK_BITS = 3;

  // control word bit positions (also the abort mask positions)
  localparam int CS_ORUN_EN = 0;
  localparam int CS_ORUN    = 1;
  localparam int CS_APERR   = 4;
  localparam int CS_WDERR   = 7;

  localparam logic [ADDR_W-1:0] LOC_ID_ABORT = 2'd0;
  localparam logic [ADDR_W-1:0] LOC_CTRL     = 2'd1;
  localparam logic [ADDR_W-1:0] LOC_ZERO     = 2'd2;
  localparam logic [ADDR_W-1:0] LOC_RDBUF    = 2'd3;

  typedef enum logic [ACK_BITS-1:0] {
    ACK_OK    = 3'b001,
    ACK_WAIT  = 3'b010,
    ACK_FAULT = 3'b100
  } ack_e;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_TRN_A, S_ACK, S_RDATA, S_TRN_B, S_WDATA, S_SKIP
  } lstate_e;

  typedef struct packed {
    logic              ap;
    logic              rnw;
    logic [ADDR_W-1:0] addr;
  } req_t;
endpackage

// File: rtl/swd_link.sv
module swd_link
  import swd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              swdio_in,
  output logic              swdio_out,
  output logic              swdio_oe,
  output req_t              req,
  output logic              hs,
  input  ack_e              ack,
  input  logic [DATA_W-1:0] rdata,
  output logic              wr_commit,
  output logic              wr_bad,
  output logic [DATA_W-1:0] wdata
);
  localparam int CW     = $clog2(DATA_W + 1);
  localparam int SKIP_N = ACK_BITS + 1;

  lstate_e             state;
  logic [CW-1:0]       cnt;
  logic [REQ_BITS-1:0] req_sr;
  logic [REQ_BITS-1:0] req_next;
  logic [ACK_BITS-1:0] ack_q;
  logic [DATA_W-1:0]   rd_sr;
  logic [DATA_W-1:0]   wd_sr;
  logic                rd_par;
  logic                wr_follow;
  logic                req_good;
  logic                last_w;

  assign req_next  = {swdio_in, req_sr[REQ_BITS-1:1]};
  assign req_good  = req_next[6] & ~req_next[5] & (req_next[4] == ^req_next[3:0]);
  assign hs        = (state == S_TRN_A);
  assign last_w    = (state == S_WDATA) && (cnt == CW'(DATA_W));
  assign wr_commit = last_w && (swdio_in == ^wd_sr);
  assign wr_bad    = last_w && (swdio_in != ^wd_sr);
  assign wdata     = wd_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      swdio_oe  <= 1'b0;
      swdio_out <= 1'b0;
      req_sr    <= '0;
      req       <= '0;
      ack_q     <= '0;
      rd_sr     <= '0;
      rd_par    <= 1'b0;
      wd_sr     <= '0;
      wr_follow <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (swdio_in) state <= S_REQ;
        end
        S_REQ: begin
          req_sr <= req_next;
          cnt    <= cnt + 1'b1;
          if (cnt == CW'(REQ_BITS - 1)) begin
            cnt <= '0;
            if (req_good) begin
              req   <= '{ap: req_next[0], rnw: req_next[1], addr: {req_next[3], req_next[2]}};
              state <= S_TRN_A;
            end else begin
              state <= S_SKIP;
            end
          end
        end
        S_TRN_A: begin
          ack_q     <= ack;
          rd_sr     <= rdata;
          rd_par    <= ^rdata;
          swdio_oe  <= 1'b1;
          swdio_out <= ack[0];
          cnt       <= '0;
          state     <= S_ACK;
        end
        S_ACK: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(0)) begin
            swdio_out <= ack_q[1];
          end else if (cnt == CW'(1)) begin
            swdio_out <= ack_q[2];
          end else begin
            cnt <= '0;
            if (ack_q == ACK_OK && req.rnw) begin
              swdio_out <= rd_sr[0];
              rd_sr     <= rd_sr >> 1;
              state     <= S_RDATA;
            end else begin
              swdio_oe  <= 1'b0;
              wr_follow <= (ack_q == ACK_OK);
              state     <= S_TRN_B;
            end
          end
        end
        S_RDATA: begin
          cnt <= cnt + 1'b1;
          if (cnt < CW'(DATA_W - 1)) begin
            swdio_out <= rd_sr[0];
            rd_sr     <= rd_sr >> 1;
          end else if (cnt == CW'(DATA_W - 1)) begin
            swdio_out <= rd_par;
          end else begin
            swdio_oe  <= 1'b0;
            wr_follow <= 1'b0;
            state     <= S_TRN_B;
          end
        end
        S_TRN_B: begin
          cnt   <= '0;
          state <= wr_follow ? S_WDATA : S_IDLE;
        end
        S_WDATA: begin
          cnt <= cnt + 1'b1;
          if (cnt < CW'(DATA_W)) wd_sr <= {swdio_in, wd_sr[DATA_W-1:1]};
          else                   state <= S_IDLE;
        end
        S_SKIP: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(SKIP_N - 1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  line_released_chk: assert property (@(posedge clk) disable iff (rst)
    (state inside {S_IDLE, S_REQ, S_WDATA, S_SKIP}) |-> !swdio_oe);
  // R2
  ack_drive_chk: assert property (@(posedge clk) disable iff (rst)
    hs |=> swdio_oe);
  // R3
  read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RDATA) |-> swdio_oe);
endmodule

// File: rtl/swd_dp_regs.sv
module swd_dp_regs
  import swd_pkg::*;
#(
  parameter logic [DATA_W-1:0] IDCODE = 32'h0BA0_0477
) (
  input  logic              clk,
  input  logic              rst,
  input  req_t              req,
  input  logic              hs,
  output ack_e              ack,
  output logic [DATA_W-1:0] rdata,
  input  logic              wr_commit,
  input  logic              wr_bad,
  input  logic [DATA_W-1:0] wdata,
  output logic              ap_valid,
  output logic              ap_write,
  output logic [ADDR_W-1:0] ap_addr,
  output logic [DATA_W-1:0] ap_wdata,
  input  logic              ap_ready,
  input  logic [DATA_W-1:0] ap_rdata,
  input  logic              ap_err
);
  logic              orun_en, orun_f, err_f, wderr_f, sticky;
  logic [DATA_W-1:0] rd_buf;
  logic [DATA_W-1:0] ctrl_word;

  assign sticky = orun_f | err_f | wderr_f;

  always_comb begin
    ctrl_word             = '0;
    ctrl_word[CS_ORUN_EN] = orun_en;
    ctrl_word[CS_ORUN]    = orun_f;
    ctrl_word[CS_APERR]   = err_f;
    ctrl_word[CS_WDERR]   = wderr_f;
  end

  always_comb begin
    ack = ACK_OK;
    if (req.ap) begin
      if (sticky)        ack = ACK_FAULT;
      else if (ap_valid) ack = ACK_WAIT;
    end
  end

  always_comb begin
    if (req.ap) begin
      rdata = rd_buf;
    end else begin
      case (req.addr)
        LOC_ID_ABORT: rdata = IDCODE;
        LOC_CTRL:     rdata = ctrl_word;
        LOC_ZERO:     rdata = '0;
        default:      rdata = rd_buf;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      orun_en  <= 1'b0;
      orun_f   <= 1'b0;
      err_f    <= 1'b0;
      wderr_f  <= 1'b0;
      rd_buf   <= '0;
      ap_valid <= 1'b0;
      ap_write <= 1'b0;
      ap_addr  <= '0;
      ap_wdata <= '0;
    end else begin
      if (wr_commit && !req.ap && req.addr == LOC_ID_ABORT) begin
        if (wdata[CS_ORUN])  orun_f  <= 1'b0;
        if (wdata[CS_APERR]) err_f   <= 1'b0;
        if (wdata[CS_WDERR]) wderr_f <= 1'b0;
      end
      if (wr_commit && !req.ap && req.addr == LOC_CTRL) orun_en <= wdata[CS_ORUN_EN];
      if (wr_bad) wderr_f <= 1'b1;
      if (hs && ack == ACK_WAIT && orun_en) orun_f <= 1'b1;
      if (ap_valid && ap_ready) begin
        ap_valid <= 1'b0;
        if (!ap_write) rd_buf <= ap_rdata;
        if (ap_err)    err_f  <= 1'b1;
      end
      if (hs && ack == ACK_OK && req.ap && req.rnw) begin
        ap_valid <= 1'b1;
        ap_write <= 1'b0;
        ap_addr  <= req.addr;
      end
      if (wr_commit && req.ap) begin
        ap_valid <= 1'b1;
        ap_write <= 1'b1;
        ap_addr  <= req.addr;
        ap_wdata <= wdata;
      end
    end
  end

  // R8 R11
  no_launch_on_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (hs && req.ap && ack != ACK_OK) |=> !$rose(ap_valid));
  // R9
  orun_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (hs && ack == ACK_WAIT && orun_en) |=> orun_f);
  // R6
  ap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ap_valid && !ap_ready) |=> (ap_valid && $stable(ap_addr) && $stable(ap_write) && $stable(ap_wdata)));
  // R10
  ap_err_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (ap_valid && ap_ready && ap_err) |=> err_f);
endmodule

// File: rtl/swd_target_port.sv
module swd_target_port
  import swd_pkg::*;
#(
  parameter logic [31:0] IDCODE = 32'h0BA0_0477
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        swdio_in,
  output logic        swdio_out,
  output logic        swdio_oe,
  output logic        ap_valid,
  output logic        ap_write,
  output logic [1:0]  ap_addr,
  output logic [31:0] ap_wdata,
  input  logic        ap_ready,
  input  logic [31:0] ap_rdata,
  input  logic        ap_err
);
  req_t              req;
  logic              hs, wr_commit, wr_bad;
  ack_e              ack;
  logic [DATA_W-1:0] rdata, wdata;

  swd_link u_link (
    .clk(clk), .rst(rst), .swdio_in(swdio_in), .swdio_out(swdio_out),
    .swdio_oe(swdio_oe), .req(req), .hs(hs), .ack(ack), .rdata(rdata),
    .wr_commit(wr_commit), .wr_bad(wr_bad), .wdata(wdata)
  );

  swd_dp_regs #(.IDCODE(IDCODE)) u_regs (
    .clk(clk), .rst(rst), .req(req), .hs(hs), .ack(ack), .rdata(rdata),
    .wr_commit(wr_commit), .wr_bad(wr_bad), .wdata(wdata),
    .ap_valid(ap_valid), .ap_write(ap_write), .ap_addr(ap_addr),
    .ap_wdata(ap_wdata), .ap_ready(ap_ready), .ap_rdata(ap_rdata), .ap_err(ap_err)
  );
endmodule

// File: tb/swd_target_port_tb.sv
module swd_target_port_tb;
  localparam int          CLK_P = 10;
  localparam logic [31:0] IDC   = 32'h4C0F_FE01;
  localparam logic [2:0]  OK = 3'b001, WT = 3'b010, FT = 3'b100;

  typedef struct packed {
    logic ap; logic rnw; logic [1:0] a; logic [31:0] wd; logic [2:0] eack; logic [31:0] erd;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 2'd0, 32'h0,         OK, IDC},           // R5 identity
    '{1'b0, 1'b0, 2'd1, 32'h0000_0001, OK, 32'h0},         // R4 write ctrl
    '{1'b0, 1'b1, 2'd1, 32'h0,         OK, 32'h0000_0001}, // R5 ctrl readback
    '{1'b1, 1'b0, 2'd1, 32'hA5A5_0F0F, OK, 32'h0},         // R6 bus write
    '{1'b1, 1'b1, 2'd1, 32'h0,         OK, 32'h0},         // R7 posted read
    '{1'b0, 1'b1, 2'd3, 32'h0,         OK, 32'hA5A5_0F0F}, // R13 buffer
    '{1'b0, 1'b1, 2'd2, 32'h0,         OK, 32'h0},         // R5 zero reg
    '{1'b1, 1'b1, 2'd2, 32'h0,         OK, 32'hA5A5_0F0F}, // R7 previous
    '{1'b0, 1'b1, 2'd3, 32'h0,         OK, 32'hC0DE_0002}  // R7 buffer fill
  };

  logic clk = 1'b0, rst = 1'b1;
  logic host_oe = 1'b1, host_val = 1'b0;
  logic swdio_out, swdio_oe, line;
  logic ap_valid, ap_write, ap_ready = 1'b0, ap_err = 1'b0;
  logic [1:0] ap_addr;
  logic [31:0] ap_wdata, ap_rdata = '0;
  logic [31:0] mem [4];
  int ap_lat = 0, ap_cnt = 0, launches = 0;
  logic ap_v_prev = 1'b0;
  int checks = 0, fails = 0;
  bit done = 0;

  assign line = swdio_oe ? swdio_out : (host_oe ? host_val : 1'b1);

  swd_target_port #(.IDCODE(IDC)) u_dut (
    .clk(clk), .rst(rst), .swdio_in(line), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
    .ap_valid(ap_valid), .ap_write(ap_write), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
    .ap_ready(ap_ready), .ap_rdata(ap_rdata), .ap_err(ap_err)
  );

  always #(CLK_P/2) clk = ~clk;

  initial for (int i = 0; i < 4; i++) mem[i] = 32'hC0DE_0000 | i;

  // bus responder: address 3 answers with an error
  always @(negedge clk) begin
    if (ap_valid && !ap_v_prev) launches <= launches + 1;
    ap_v_prev <= ap_valid;
    if (ap_ready) begin
      ap_ready <= 1'b0; ap_cnt <= 0;
    end else if (ap_valid) begin
      if (ap_cnt >= ap_lat) begin
        ap_ready <= 1'b1; ap_rdata <= mem[ap_addr]; ap_err <= (ap_addr == 2'd3);
        if (ap_write) mem[ap_addr] <= ap_wdata;
      end else ap_cnt <= ap_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic drv, input logic v, output logic seen, output logic oe_seen);
    @(negedge clk);
    seen = line; oe_seen = swdio_oe;
    host_oe = drv; host_val = v;
  endtask

  task automatic xfer(input logic ap, input logic rnw, input logic [1:0] a, input logic [31:0] wd,
                      input logic bad_rp, input logic bad_wp, output logic [2:0] ack,
                      output logic [31:0] rd, output logic par_ok, output logic drove);
    logic s, o;
    logic [7:0] rq;
    rq = {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1] ^ bad_rp, a[1], a[0], rnw, ap, 1'b1};
    drove = 0; ack = '0; rd = '0; par_ok = 1;
    for (int i = 0; i < 8; i++) step(1'b1, rq[i], s, o);
    step(1'b0, 1'b0, s, o); drove |= o;
    for (int i = 0; i < 3; i++) begin step(1'b0, 1'b0, s, o); ack[i] = s; drove |= o; end
    if (!bad_rp) begin
      if (ack == OK && rnw) begin
        for (int i = 0; i < 32; i++) begin step(1'b0, 1'b0, s, o); rd[i] = s; end
        step(1'b0, 1'b0, s, o); par_ok = (s == ^rd);
        step(1'b0, 1'b0, s, o);
      end else if (ack == OK) begin
        step(1'b0, 1'b0, s, o);
        for (int i = 0; i < 32; i++) step(1'b1, wd[i], s, o);
        step(1'b1, (^wd) ^ bad_wp, s, o);
      end else begin
        step(1'b0, 1'b0, s, o);
      end
    end
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0, s, o);
  endtask

  task automatic do_rd(input logic ap, input logic [1:0] a, input logic [2:0] eack,
                       input logic [31:0] ed, input string tag);
    logic [2:0] k; logic [31:0] d; logic p, dr;
    xfer(ap, 1'b1, a, '0, 1'b0, 1'b0, k, d, p, dr);
    chk({tag, " R2 ack"}, {29'd0, k}, {29'd0, eack});
    if (eack == OK) begin
      chk({tag, " data"}, d, ed);
      chk({tag, " R3 parity"}, {31'd0, p}, 32'd1);
    end
  endtask

  task automatic do_wr(input logic ap, input logic [1:0] a, input logic [31:0] wd,
                       input logic bad_wp, input logic [2:0] eack, input string tag);
    logic [2:0] k; logic [31:0] d; logic p, dr;
    xfer(ap, 1'b0, a, wd, 1'b0, bad_wp, k, d, p, dr);
    chk({tag, " R2 ack"}, {29'd0, k}, {29'd0, eack});
  endtask

  task automatic idle(input int n);
    logic s, o;
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, s, o);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int l0;
    logic [2:0] k; logic [31:0] d; logic p, dr;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R14 line released", {31'd0, swdio_oe}, 32'd0);
    chk("R14 no bus access", {31'd0, ap_valid}, 32'd0);
    idle(2);
    do_rd(1'b0, 2'd1, OK, 32'h0, "R14 ctrl zero");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].rnw) do_rd(VEC[v].ap, VEC[v].a, VEC[v].eack, VEC[v].erd, $sformatf("vec%0d", v));
      else            do_wr(VEC[v].ap, VEC[v].a, VEC[v].wd, 1'b0, VEC[v].eack, $sformatf("vec%0d", v));
      idle(2);
    end

    // R1 malformed request: no response, no bus access, link still usable
    l0 = launches;
    xfer(1'b1, 1'b1, 2'd0, '0, 1'b1, 1'b0, k, d, p, dr);
    chk("R1 no drive on bad request", {31'd0, dr}, 32'd0);
    chk("R1 no bus access", launches, l0);
    do_rd(1'b0, 2'd0, OK, IDC, "R1 recovery identity");

    // R4 bad write parity, then R11 refusal, R12 abort
    do_wr(1'b0, 2'd1, 32'h0, 1'b1, OK, "R4 bad parity write");
    do_rd(1'b0, 2'd1, OK, 32'h0000_0081, "R4 data error flag, write discarded");
    l0 = launches;
    do_rd(1'b1, 2'd0, FT, 32'h0, "R11 read refused");
    do_wr(1'b1, 2'd0, 32'hDEAD_BEEF, 1'b0, FT, "R11 write refused");
    idle(4);
    chk("R11 no bus access", launches, l0);
    do_rd(1'b0, 2'd3, OK, 32'hC0DE_0002, "R11 local read still OK");
    do_wr(1'b0, 2'd0, 32'h0000_0080, 1'b0, OK, "R12 abort");
    do_rd(1'b0, 2'd1, OK, 32'h0000_0001, "R12 flag cleared");

    // R8 / R9 with overrun detection on
    ap_lat = 80;
    do_rd(1'b1, 2'd0, OK, 32'hC0DE_0002, "R7 slow read");
    l0 = launches;
    do_rd(1'b1, 2'd1, WT, 32'h0, "R8 busy");
    chk("R8 no new access", launches, l0);
    do_rd(1'b0, 2'd1, OK, 32'h0000_0003, "R9 overrun latched");
    idle(120);
    do_rd(1'b1, 2'd1, FT, 32'h0, "R11 fault on overrun");
    do_wr(1'b0, 2'd0, 32'h0000_0002, 1'b0, OK, "R12 abort overrun");
    do_rd(1'b0, 2'd1, OK, 32'h0000_0001, "R12 overrun cleared");
    do_rd(1'b0, 2'd3, OK, 32'hC0DE_0000, "R11 refused write left data, R7 buffer");

    // R9 with overrun detection off
    do_wr(1'b0, 2'd1, 32'h0, 1'b0, OK, "R5 ctrl clear");
    do_rd(1'b1, 2'd1, OK, 32'hC0DE_0000, "R7 posted result");
    do_rd(1'b1, 2'd1, WT, 32'h0, "R8 busy again");
    do_rd(1'b0, 2'd1, OK, 32'h0, "R9 no overrun when disabled");
    idle(120);
    do_rd(1'b0, 2'd3, OK, 32'hA5A5_0F0F, "R7 buffer filled");

    // R10 bus error
    ap_lat = 0;
    do_wr(1'b1, 2'd3, 32'h0000_1234, 1'b0, OK, "R10 erroring write");
    idle(4);
    do_rd(1'b0, 2'd1, OK, 32'h0000_0010, "R10 bus error flag");
    do_rd(1'b1, 2'd0, FT, 32'h0, "R11 fault on bus error");
    do_wr(1'b0, 2'd0, 32'h0000_0010, 1'b0, OK, "R12 abort bus error");
    do_rd(1'b0, 2'd1, OK, 32'h0, "R12 bus error cleared");

    // R13 buffer retained, no bus access
    l0 = launches;
    do_rd(1'b0, 2'd3, OK, 32'hA5A5_0F0F, "R13 buffer first");
    do_rd(1'b0, 2'd3, OK, 32'hA5A5_0F0F, "R13 buffer again");
    chk("R13 no bus access", launches, l0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule